// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches an I2C bus as a slave and decides whether the first byte after a START is addressed to it. SCL and SDA are brought into the system clock domain through a chain of flip-flops. The block recognises START and STOP conditions from the synchronized lines and shifts in eight bits, most significant bit first, on rising SCL edges. The first seven bits are the address and the eighth is the read/write flag, where 1 means read.

The block's own 7-bit address is built from two sources. Four high bits and one middle bit come from a 24-bit configuration register, which only the local processor port can access. The two remaining bits come from strap pins. The received address is compared with this own address and also with the all-zero general call address. The two are accepted in the same way. On a hit, the block pulses a match flag, latches the read/write bit and a general-call indicator, and pulls SDA low during the ninth clock.

The block has no streaming data path, so every pin is a plain control or status signal. Handling of data bytes after the address is out of scope. After an acknowledge, and after a miss, the block waits for the next START.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: The configuration register keeps address bits A6..A3 in register bits 23:20 (A6 at bit 23) and bit A1 in register bit 18. A write stores these bits, and `cfg_rd_data` returns them in the same positions.
- R2: Register bits 19 and 17..0 always read as zero. Writing ones to them has no effect on the read value or on the matched address.
- R3: After `rst_n` low, or after a one-cycle `soft_rst` pulse, the register reads 0xB00000. That is A6..A3 = 1011 and A1 = 0, so the own address is 1011, `strap_a2`, 0, `strap_a0`.
- R4: The own address is {reg[23:20], `strap_a2`, reg[18], `strap_a0`}. The received byte after START carries address bits A6..A0 on the first seven SCL rising edges and the read/write bit on the eighth.
- R5: When the received address equals the own address, `addr_match` is high for exactly one clock and `rw_bit` takes the eighth bit. `gc_hit` is 0 unless the address is also all zeros.
- R6: A received address of seven zeros is accepted with either read/write value, exactly like the own address, and `gc_hit` reads 1.
- R7: On a hit, `sda_drive_low` rises after the SCL falling edge that ends the eighth bit. It stays high through the ninth SCL high phase and falls after the next SCL falling edge. It is never high while the eighth bit is on the bus.
- R8: On a miss, SDA is never driven and `addr_match` does not pulse. Bytes clocked afterwards without a new START are ignored, even if one equals the own address.
- R9: A repeated START abandons any partly received byte and begins address reception again.
- R10: A STOP returns the block to idle, so bits clocked after a STOP with no START are ignored.
- R11: While `i2c_slave_en` is 0, no acknowledge is driven and `addr_match` never pulses, whatever the bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset: reloads the register default and returns the recognizer to idle |
| i2c_slave_en | input | 1 | 1 when the interface operates as an I2C slave |
| cfg_wr_en | input | 1 | Local processor write strobe for the address register |
| cfg_wr_data | input | 24 | Local processor write data |
| cfg_rd_data | output | 24 | Address register read value |
| strap_a2 | input | 1 | Strap pin supplying address bit A2 |
| strap_a0 | input | 1 | Strap pin supplying address bit A0 |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_match | output | 1 | One-cycle pulse on an accepted address |
| rw_bit | output | 1 | Read/write bit of the last accepted address |
| gc_hit | output | 1 | Last accepted address was the general call |

## Verification
The bench sweeps all 256 address/direction bytes against one configuration. It then runs every combination of register bits and strap pins, sending the own address and a neighbour one bit away. A design that placed a strap or register bit in the wrong position, or that dropped the general call, would acknowledge the wrong bytes. Separate scenarios cover a byte equal to the own address arriving after a miss or after a STOP without a START; a design that kept listening would acknowledge it. A repeated START is sent in the middle of a byte, so a design that did not clear its bit count would misalign the address. The bench also checks the release of SDA after the ninth clock, because holding it one edge too long would corrupt the next bit.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  localparam int REG_W    = 24;
  localparam int HI_MSB   = 23;
  localparam int HI_LSB   = 20;
  localparam int HI_W     = HI_MSB - HI_LSB + 1;
  localparam int A1_BIT   = 18;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = ADDR_W + 1;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam logic [HI_W-1:0] HI_RST = 4'b1011;
  localparam logic            A1_RST = 1'b0;

  localparam logic [REG_W-1:0] USED_MASK =
    ({{(REG_W-HI_W){1'b0}}, {HI_W{1'b1}}} << HI_LSB) |
    ({{(REG_W-1){1'b0}}, 1'b1} << A1_BIT);

  localparam logic [REG_W-1:0] REG_DEFAULT =
    ({{(REG_W-HI_W){1'b0}}, HI_RST} << HI_LSB) |
    ({{(REG_W-1){1'b0}}, A1_RST} << A1_BIT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/i2c_ar_sync.sv
module i2c_ar_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out,
  output logic [W-1:0] q_prev
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign q_out[g] = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev[g] <= 1'b1;
      else        q_prev[g] <= chain[STAGES-1];
    end
  end
endmodule

// File: rtl/i2c_ar_cond.sv
module i2c_ar_cond (
  input  logic scl,
  input  logic sda,
  input  logic scl_p,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  always_comb begin
    scl_rise = scl & ~scl_p;
    scl_fall = ~scl & scl_p;
    start_c  = scl & scl_p & sda_p & ~sda;
    stop_c   = scl & scl_p & ~sda_p & sda;
  end
endmodule

// File: rtl/i2c_ar_cfg.sv
module i2c_ar_cfg
  import i2c_ar_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic [HI_W-1:0]     hi_bits,
  output logic                a1_bit
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_q <= REG_DEFAULT;
    else if (soft_rst) reg_q <= REG_DEFAULT;
    else if (wr_en)    reg_q <= wr_data & USED_MASK;
  end

  assign rd_data = reg_q;
  assign hi_bits = reg_q[HI_MSB:HI_LSB];
  assign a1_bit  = reg_q[A1_BIT];

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> ((rd_data & USED_MASK) == ($past(wr_data) & USED_MASK)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & ~USED_MASK) == '0));

  assert_soft_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data == REG_DEFAULT));
endmodule

// File: rtl/i2c_ar_rx.sv
module i2c_ar_rx
  import i2c_ar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              mode_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  output logic              drive_low,
  output logic              match_pulse,
  output logic              rw_q,
  output logic              gc_q
);
  rx_state_e         state;
  logic [BYTE_W-2:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shift_nxt;
  logic [ADDR_W-1:0] rx_addr;
  logic              is_gc;
  logic              hit;

  always_comb begin
    shift_nxt = {shreg, sda};
    rx_addr   = shift_nxt[BYTE_W-1:1];
    is_gc     = (rx_addr == '0);
    hit       = is_gc || (rx_addr == own_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      cnt         <= '0;
      match_pulse <= 1'b0;
      rw_q        <= 1'b0;
      gc_q        <= 1'b0;
    end else if (soft_rst || !mode_en) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      match_pulse <= 1'b0;
      if (soft_rst) begin
        rw_q <= 1'b0;
        gc_q <= 1'b0;
      end
    end else begin
      match_pulse <= 1'b0;
      if (start_c) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_c) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg <= shift_nxt[BYTE_W-2:0];
            if (cnt == CNT_W'(BYTE_W-1)) begin
              if (hit) begin
                state       <= ST_ACK_WAIT;
                match_pulse <= 1'b1;
                rw_q        <= shift_nxt[0];
                gc_q        <= is_gc;
              end else begin
                state <= ST_HOLD;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_WAIT: if (scl_fall) state <= ST_ACK;
          ST_ACK:      if (scl_fall) state <= ST_HOLD;
          default: ;
        endcase
      end
    end
  end

  assign drive_low = (state == ST_ACK);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  assert_ack_starts_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(scl_fall));

  assert_ack_ends_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> ($past(scl_fall) || $past(!mode_en) || $past(soft_rst)));

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!drive_low && !match_pulse));
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
  import i2c_ar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             i2c_slave_en,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             strap_a2,
  input  logic             strap_a0,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_drive_low,
  output logic             addr_match,
  output logic             rw_bit,
  output logic             gc_hit
);
  logic [1:0]        line_s, line_p;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [HI_W-1:0]   hi_bits;
  logic              a1_bit;
  logic [ADDR_W-1:0] own_addr;

  i2c_ar_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   ({scl_in, sda_in}),
    .q_out  (line_s),
    .q_prev (line_p)
  );

  i2c_ar_cond u_cond (
    .scl      (line_s[1]),
    .sda      (line_s[0]),
    .scl_p    (line_p[1]),
    .sda_p    (line_p[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2c_ar_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .hi_bits (hi_bits),
    .a1_bit  (a1_bit)
  );

  assign own_addr = {hi_bits, strap_a2, a1_bit, strap_a0};

  i2c_ar_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .mode_en    (i2c_slave_en),
    .own_addr   (own_addr),
    .sda        (line_s[0]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_c    (start_c),
    .stop_c     (stop_c),
    .drive_low  (sda_drive_low),
    .match_pulse(addr_match),
    .rw_q       (rw_bit),
    .gc_q       (gc_hit)
  );
endmodule

// File: tb/test_i2c_addr_recognizer.sv
module test_i2c_addr_recognizer;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        mode_en = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [23:0] cfg_wr_data = '0;
  logic [23:0] cfg_rd_data;
  logic        strap_a2 = 1'b1;
  logic        strap_a0 = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_bus;
  logic        sda_drive_low, addr_match, rw_bit, gc_hit;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  bit done = 0;

  assign sda_bus = sda_m & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_recognizer i_i2c_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .i2c_slave_en(mode_en),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .strap_a2(strap_a2), .strap_a0(strap_a0), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .addr_match(addr_match), .rw_bit(rw_bit),
    .gc_hit(gc_hit)
  );

  always @(posedge clk) if (addr_match) pulse_cnt <= pulse_cnt + 1;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [23:0] d);
    cfg_wr_data = d; cfg_wr_en = 1'b1; w(1); cfg_wr_en = 1'b0; w(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  // eight bits MSB first; checks nothing drives SDA during the eighth bit (R7)
  task automatic send_byte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 1; i--) send_bit(b[i]);
    sda_m = b[0]; w(Q); scl_m = 1'b1; w(Q);
    chk(sda_drive_low == 1'b0, "R7", {req, " no drive in bit 8"}, sda_drive_low, 0);
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  // ninth clock: ack observed on the bus, then released after the fall (R7)
  task automatic ninth(input bit exp_ack, input string req);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    chk(sda_bus == !exp_ack, req, "ack level on ninth clock", sda_bus, !exp_ack);
    w(Q); scl_m = 1'b0; w(2*Q);
    chk(sda_drive_low == 1'b0, "R7", "SDA released after ninth fall", sda_drive_low, 0);
  endtask

  function automatic bit expect_hit(input logic [6:0] a, input logic [6:0] own);
    return mode_en && ((a == own) || (a == 7'd0));
  endfunction

  task automatic addr_txn(input logic [6:0] a, input logic rw,
                          input logic [6:0] own, input string req);
    int  p0;
    bit  e;
    p0 = pulse_cnt;
    e  = expect_hit(a, own);
    bus_start();
    send_byte({a, rw}, req);
    ninth(e, req);
    chk((pulse_cnt - p0) == (e ? 1 : 0), req, "match pulse count", pulse_cnt - p0, e ? 1 : 0);
    if (e) begin
      chk(rw_bit == rw, "R5", "latched rw", rw_bit, rw);
      chk(gc_hit == (a == 7'd0), "R6", "gc flag", gc_hit, (a == 7'd0));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] own;
    int p0;
    w(4); rst_n = 1'b1; w(4);

    // R3 reset state
    chk(cfg_rd_data == 24'hB00000, "R3", "register after hw reset", cfg_rd_data, 24'hB00000);
    chk(sda_drive_low == 0 && addr_match == 0, "R3", "outputs idle after reset",
        {sda_drive_low, addr_match}, 0);

    // R4/R5/R6 full sweep on default config, straps 1,1 -> own = 1011_1_0_1
    own = {4'b1011, strap_a2, 1'b0, strap_a0};
    for (int a = 0; a < 128; a++)
      for (int r = 0; r < 2; r++)
        addr_txn(7'(a), r[0], own, "R4");

    // R1/R2 register layout and reserved bits
    cfg_write(24'hFFFFFF);
    chk(cfg_rd_data == 24'hF40000, "R2", "all-ones write", cfg_rd_data, 24'hF40000);
    cfg_write(24'h0BFFFF);
    chk(cfg_rd_data == 24'h000000, "R2", "reserved-only write", cfg_rd_data, 0);
    cfg_write(24'hA40000);
    chk(cfg_rd_data == 24'hA40000, "R1", "field write", cfg_rd_data, 24'hA40000);

    // R1/R4 sweep every register/strap combination
    for (int hi = 0; hi < 16; hi++)
      for (int a1 = 0; a1 < 2; a1++)
        for (int st = 0; st < 4; st++) begin
          cfg_write((24'(hi) << 20) | (24'(a1) << 18) | 24'h0B_FFFF);
          strap_a2 = st[1]; strap_a0 = st[0];
          own = {hi[3:0], st[1], a1[0], st[0]};
          addr_txn(own, hi[0], own, "R1");
          addr_txn(own ^ (7'd1 << ((hi + st) % 7)), a1[0], own, "R4");
        end

    // R3 software reset
    cfg_write(24'h000000);
    soft_rst = 1'b1; w(1); soft_rst = 1'b0; w(1);
    chk(cfg_rd_data == 24'hB00000, "R3", "register after soft reset", cfg_rd_data, 24'hB00000);
    strap_a2 = 1'b0; strap_a0 = 1'b1;
    own = 7'b1011001;
    addr_txn(own, 1'b0, own, "R3");

    // R8 miss then own byte without START
    p0 = pulse_cnt;
    bus_start();
    send_byte({own ^ 7'h40, 1'b0}, "R8");
    ninth(1'b0, "R8");
    send_byte({own, 1'b0}, "R8");
    ninth(1'b0, "R8");
    bus_stop();
    chk(pulse_cnt == p0, "R8", "no pulse after miss", pulse_cnt - p0, 0);

    // R10 byte after STOP without START
    p0 = pulse_cnt;
    scl_m = 1'b0; w(Q);
    send_byte({own, 1'b1}, "R10");
    ninth(1'b0, "R10");
    bus_stop();
    chk(pulse_cnt == p0, "R10", "no pulse after stop", pulse_cnt - p0, 0);

    // R9 repeated START in the middle of a byte
    p0 = pulse_cnt;
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte({own, 1'b1}, "R9");
    ninth(1'b1, "R9");
    chk(pulse_cnt == p0 + 1, "R9", "pulse after restart", pulse_cnt - p0, 1);
    chk(rw_bit == 1'b1, "R9", "rw after restart", rw_bit, 1);
    bus_stop();

    // R11 mode off
    mode_en = 1'b0; w(2);
    addr_txn(own, 1'b0, own, "R11");
    addr_txn(7'd0, 1'b0, own, "R11");
    mode_en = 1'b1; w(2);
    addr_txn(own, 1'b0, own, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule